// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for an external display link in the pixel clock domain. It drives horizontal sync, vertical sync, a data-enable strobe and a pixel request toward an upstream pixel source. It also drives the final output pixel, which is the upstream pixel, a border colour or an underflow fill colour. All geometry is programmed through a simple write port (strobe, address, data). Vertical quantities are absolute pixel-clock counts measured from the leading edge of vsync, and every frame begins with the sync pulse, not with active video.

Writes land in shadow registers. While the block runs, the shadow set is copied into the working set only on the last pixel clock of a frame, so a frame is never built from a mix of old and new settings. Clearing the enable bit therefore stops the raster only at the end of the current frame. A one-cycle frame tick marks each frame boundary, so software can see that a disable has taken hold. When idle, the working set follows the shadow set every clock and the counters sit at zero.

Top module: `dtg_top`

## Requirements
- R1: During and right after reset, every output is low: hsync, vsync, data-enable, pixel request, frame tick, and a pixel of 0. The border colour resets to 0.
- R2: When enable (control register at address 0, bit 0) is set while idle, the counters start on the next clock. The first output cycle comes two clocks after the write edge, with both syncs active.
- R3: The line period field is line register bits [27:16] at address 1, and the sync width field is bits [11:0]. Hsync is active for the first width clocks of each line. Lines restart at every frame start.
- R4: The frame period (address 2) is a count of pixel clocks. Vsync is active for the first N clocks of the frame, where N is the vsync length (address 3).
- R5: Data-enable is high when the line position lies in [start, end] and the frame position lies in [vstart+skew, vend+skew]. The horizontal start is at address 4 bits [11:0], the horizontal end at address 4 bits [27:16], vstart at address 5, vend at address 6 and skew at address 7. The pixel request carries the same condition one clock ahead of data-enable.
- R6: A non-zero skew moves both vertical window edges later by that many pixel clocks.
- R7: Control bit 1 makes hsync active-low and control bit 2 makes vsync active-low, each on its own.
- R8: Inside the window, the output pixel is the upstream pixel sampled one clock earlier. Outside the window, it is the border colour (address 8).
- R9: With recovery off (control bit 3 clear), a window pixel without upstream valid data is replaced by the fill colour (address 9), and only that pixel.
- R10: With recovery on, the first starved window pixel turns the rest of that frame's window to fill colour. The next frame starts clean.
- R11: Writes made mid-frame do not change the current frame. They apply from the next frame start.
- R12: A cleared enable stops the raster at the end of the current frame. The frame tick pulses for one clock with the first output cycle of each new frame, or of the first idle cycle. While idle, data-enable is low, the syncs sit at their inactive levels with polarity applied, and the pixel is the border colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 32 | Register write data |
| pix_valid_i | input | 1 | Upstream pixel is present this clock |
| pix_data_i | input | 24 | Upstream pixel value |
| pix_req_o | output | 1 | Pixel request, one clock ahead of data-enable |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data-enable |
| pix_o | output | 24 | Output pixel |
| frame_tick_o | output | 1 | One-clock pulse at each frame boundary |

## Verification
The bench starves the source on a window pixel twice: once with recovery off, and once with recovery on, followed by a clean frame. A design that keeps the sticky fill across a frame boundary shows fill in the third frame. A design that ignores recovery shows real pixels after the starve. Skew, polarity and window edges are rewritten in the middle of a frame. A design that copies settings immediately tears the first frame, and one that never copies them misses the shifted window and the inverted syncs in the second. A disable written mid-frame must not cut the frame short, and the idle state after it must show inverted syncs, the border colour and a single tick. Off-by-one errors in window edges, line wrap or request lead show up as mismatches on individual cycles against the scoreboard.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int HCW  = 12;   // line position width
    localparam int FCW  = 24;   // frame position width (pixel clocks)
    localparam int PXW  = 24;   // pixel width
    localparam int AW   = 4;    // register address width
    localparam int DW   = 32;   // register data width
    localparam int HFLD = 16;   // offset of the upper field in packed horizontal registers

    localparam logic [AW-1:0] ADDR_CTRL   = AW'(0);
    localparam logic [AW-1:0] ADDR_LINE   = AW'(1);
    localparam logic [AW-1:0] ADDR_FRAME  = AW'(2);
    localparam logic [AW-1:0] ADDR_VLEN   = AW'(3);
    localparam logic [AW-1:0] ADDR_HWIN   = AW'(4);
    localparam logic [AW-1:0] ADDR_VFIRST = AW'(5);
    localparam logic [AW-1:0] ADDR_VLAST  = AW'(6);
    localparam logic [AW-1:0] ADDR_SKEW   = AW'(7);
    localparam logic [AW-1:0] ADDR_BORDER = AW'(8);
    localparam logic [AW-1:0] ADDR_FILL   = AW'(9);

    localparam int BIT_EN    = 0;
    localparam int BIT_HPOL  = 1;
    localparam int BIT_VPOL  = 2;
    localparam int BIT_RECOV = 3;

    typedef struct packed {
        logic           en;
        logic           hpol;
        logic           vpol;
        logic           recov;
        logic [HCW-1:0] hsw;
        logic [HCW-1:0] line;
        logic [HCW-1:0] hs;
        logic [HCW-1:0] he;
        logic [FCW-1:0] frame;
        logic [FCW-1:0] vlen;
        logic [FCW-1:0] vs;
        logic [FCW-1:0] ve;
        logic [FCW-1:0] skew;
        logic [PXW-1:0] border;
        logic [PXW-1:0] fill;
    } dtg_cfg_t;

    typedef struct packed {
        logic           run;
        logic           tick;
        logic [HCW-1:0] h;
        logic [FCW-1:0] f;
        dtg_cfg_t       cfg;
    } dtg_cnt_t;

    typedef struct packed {
        logic           hs;
        logic           vs;
        logic           de;
        logic           tick;
        logic           uf;
        logic [PXW-1:0] px;
    } dtg_pix_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    output dtg_cfg_t      shadow_o
);
    dtg_cfg_t sh_d, sh_q;
    logic     unused_bits;

    assign unused_bits = ^wr_data_i;

    always_comb begin
        sh_d = sh_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_CTRL: begin
                    sh_d.en    = wr_data_i[BIT_EN];
                    sh_d.hpol  = wr_data_i[BIT_HPOL];
                    sh_d.vpol  = wr_data_i[BIT_VPOL];
                    sh_d.recov = wr_data_i[BIT_RECOV];
                end
                ADDR_LINE: begin
                    sh_d.hsw  = wr_data_i[HCW-1:0];
                    sh_d.line = wr_data_i[HFLD+HCW-1:HFLD];
                end
                ADDR_FRAME:  sh_d.frame = wr_data_i[FCW-1:0];
                ADDR_VLEN:   sh_d.vlen  = wr_data_i[FCW-1:0];
                ADDR_HWIN: begin
                    sh_d.hs = wr_data_i[HCW-1:0];
                    sh_d.he = wr_data_i[HFLD+HCW-1:HFLD];
                end
                ADDR_VFIRST: sh_d.vs     = wr_data_i[FCW-1:0];
                ADDR_VLAST:  sh_d.ve     = wr_data_i[FCW-1:0];
                ADDR_SKEW:   sh_d.skew   = wr_data_i[FCW-1:0];
                ADDR_BORDER: sh_d.border = wr_data_i[PXW-1:0];
                ADDR_FILL:   sh_d.fill   = wr_data_i[PXW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign shadow_o = sh_q;

    // R11: a write lands in the shadow copy on the next clock
    assert_frame_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == ADDR_FRAME) |=> (shadow_o.frame == $past(wr_data_i[FCW-1:0])));
    // R1: border colour comes out of reset as zero and changes only by a write
    assert_border_write_only_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && wr_addr_i == ADDR_BORDER) |=> $stable(shadow_o.border));
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters
    import dtg_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  dtg_cfg_t       shadow_i,
    output dtg_cfg_t       cfg_o,
    output logic           run_o,
    output logic [HCW-1:0] h_o,
    output logic [FCW-1:0] f_o,
    output logic           tick_o
);
    dtg_cnt_t       c_d, c_q;
    logic [FCW:0]   f_nxt;
    logic [HCW:0]   h_nxt;
    logic           last_clk;

    always_comb begin
        f_nxt    = {1'b0, c_q.f} + 1'b1;
        h_nxt    = {1'b0, c_q.h} + 1'b1;
        last_clk = c_q.run && (f_nxt >= {1'b0, c_q.cfg.frame});
        c_d      = c_q;
        c_d.tick = 1'b0;
        if (!c_q.run) begin
            c_d.cfg = shadow_i;
            c_d.h   = '0;
            c_d.f   = '0;
            c_d.run = shadow_i.en;
        end else if (last_clk) begin
            c_d.cfg  = shadow_i;
            c_d.h    = '0;
            c_d.f    = '0;
            c_d.run  = shadow_i.en;
            c_d.tick = 1'b1;
        end else begin
            c_d.f = f_nxt[FCW-1:0];
            c_d.h = (h_nxt >= {1'b0, c_q.cfg.line}) ? '0 : h_nxt[HCW-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign cfg_o  = c_q.cfg;
    assign run_o  = c_q.run;
    assign h_o    = c_q.h;
    assign f_o    = c_q.f;
    assign tick_o = c_q.tick;

    // R3: line position stays inside the programmed line period
    assert_line_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.run && c_q.cfg.line != '0) |-> (c_q.h < c_q.cfg.line));
    // R4: frame position stays inside the programmed frame period
    assert_frame_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.run && c_q.cfg.frame != '0) |-> (c_q.f < c_q.cfg.frame));
    // R2: the raster starts at the sync corner
    assert_start_at_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(c_q.run) |-> (c_q.h == '0 && c_q.f == '0));
    // R11: working settings are frozen inside a frame
    assert_cfg_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.run && c_q.f != '0) |-> $stable(c_q.cfg));
    // R12: boundary pulse only at the frame origin
    assert_tick_at_origin_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c_q.tick |-> (c_q.f == '0 && c_q.h == '0));
endmodule

// File: rtl/dtg_pixel.sv
module dtg_pixel
    import dtg_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  dtg_cfg_t       cfg_i,
    input  logic           run_i,
    input  logic [HCW-1:0] h_i,
    input  logic [FCW-1:0] f_i,
    input  logic           tick_i,
    input  logic           pix_valid_i,
    input  logic [PXW-1:0] pix_data_i,
    output logic           req_o,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           de_o,
    output logic [PXW-1:0] pix_o,
    output logic           tick_o
);
    dtg_pix_t       p_d, p_q;
    logic [FCW-1:0] v_first, v_last;
    logic           in_h, in_v, de_now, starve, restart, use_fill;
    logic           unused_cfg;

    assign unused_cfg = cfg_i.en ^ (^cfg_i.frame) ^ (^cfg_i.line);

    always_comb begin
        v_first  = cfg_i.vs + cfg_i.skew;
        v_last   = cfg_i.ve + cfg_i.skew;
        in_h     = (h_i >= cfg_i.hs) && (h_i <= cfg_i.he);
        in_v     = (f_i >= v_first) && (f_i <= v_last);
        de_now   = run_i && in_h && in_v;
        starve   = de_now && !pix_valid_i;
        restart  = !run_i || (f_i == '0);
        use_fill = starve || (cfg_i.recov && p_q.uf && !restart);

        p_d      = p_q;
        p_d.hs   = (run_i && (h_i < cfg_i.hsw)) ^ cfg_i.hpol;
        p_d.vs   = (run_i && (f_i < cfg_i.vlen)) ^ cfg_i.vpol;
        p_d.de   = de_now;
        p_d.tick = tick_i;
        p_d.uf   = cfg_i.recov && (starve || (p_q.uf && !restart));
        if (!de_now)       p_d.px = cfg_i.border;
        else if (use_fill) p_d.px = cfg_i.fill;
        else               p_d.px = pix_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end

    assign req_o   = de_now;
    assign hsync_o = p_q.hs;
    assign vsync_o = p_q.vs;
    assign de_o    = p_q.de;
    assign pix_o   = p_q.px;
    assign tick_o  = p_q.tick;

    // R5: a request is answered by data-enable one clock later
    assert_req_leads_de_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |=> de_o);
    // R9: a starved window pixel becomes the fill colour
    assert_fill_on_starve_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && !pix_valid_i) |=> (pix_o == $past(cfg_i.fill)));
    // R10: with recovery latched, later window pixels of the frame stay filled
    assert_recovery_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (p_q.uf && cfg_i.recov && run_i && f_i != '0 && req_o) |=> (pix_o == $past(cfg_i.fill)));
    // R8: outside the window the border colour is driven
    assert_border_outside_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_o |=> (pix_o == $past(cfg_i.border)));
    // R12: idle raster keeps syncs at their inactive levels
    assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!de_o && hsync_o == $past(cfg_i.hpol) && vsync_o == $past(cfg_i.vpol)));
endmodule

// File: rtl/dtg_top.sv
module dtg_top
    import dtg_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  wr_addr_i,
    input  logic [DW-1:0]  wr_data_i,
    input  logic           pix_valid_i,
    input  logic [PXW-1:0] pix_data_i,
    output logic           pix_req_o,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           de_o,
    output logic [PXW-1:0] pix_o,
    output logic           frame_tick_o
);
    dtg_cfg_t       shadow;
    dtg_cfg_t       working;
    logic           run;
    logic [HCW-1:0] hpos;
    logic [FCW-1:0] fpos;
    logic           wrap_tick;

    dtg_regs u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .shadow_o  (shadow)
    );

    dtg_counters u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .shadow_i (shadow),
        .cfg_o    (working),
        .run_o    (run),
        .h_o      (hpos),
        .f_o      (fpos),
        .tick_o   (wrap_tick)
    );

    dtg_pixel u_pix (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_i       (working),
        .run_i       (run),
        .h_i         (hpos),
        .f_i         (fpos),
        .tick_i      (wrap_tick),
        .pix_valid_i (pix_valid_i),
        .pix_data_i  (pix_data_i),
        .req_o       (pix_req_o),
        .hsync_o     (hsync_o),
        .vsync_o     (vsync_o),
        .de_o        (de_o),
        .pix_o       (pix_o),
        .tick_o      (frame_tick_o)
    );
endmodule

// File: tb/tb_dtg_top.sv
`timescale 1ns/1ps
module tb_dtg_top;
    typedef struct {
        int          cyc;
        bit          hs, vs, de, tk;
        logic [23:0] px;
        string       tag;
    } item_t;

    typedef struct {
        int line, hsw, frame, vlen, hs, he, vs, ve, skew;
        bit hpol, vpol, recov;
        logic [23:0] border, fill;
    } bcfg_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_data = '0;
    logic        pix_req, hsync, vsync, de, tick;
    logic [23:0] pix;

    int total = 0, bad = 0, cyc = 0;
    int sa = -100, sb = -100;
    bit prev_req = 1'b0;
    item_t sbq[$];
    item_t mit;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dtg_top dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .pix_valid_i(pix_valid), .pix_data_i(pix_data),
        .pix_req_o(pix_req), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
        .pix_o(pix), .frame_tick_o(tick)
    );

    function automatic logic [23:0] pd(int c);
        return {8'hA5, 16'(c)};
    endfunction

    function automatic bit pv(int c);
        return !(c == sa || c == sb);
    endfunction

    always @(negedge clk) begin
        pix_valid <= pv(cyc);
        pix_data  <= pd(cyc);
    end

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s cyc=%0d act=%h exp=%h", tag, what, cyc, act, exp);
        end
    endtask

    // monitor: pop the expectation due this cycle and compare
    always @(negedge clk) begin
        if (sbq.size() > 0 && sbq[0].cyc == cyc) begin
            mit = sbq.pop_front();
            chk(hsync == mit.hs, mit.tag, "hsync", 32'(hsync), 32'(mit.hs));
            chk(vsync == mit.vs, mit.tag, "vsync", 32'(vsync), 32'(mit.vs));
            chk(de == mit.de, mit.tag, "de", 32'(de), 32'(mit.de));
            chk(prev_req == mit.de, mit.tag, "req", 32'(prev_req), 32'(mit.de));
            chk(pix == mit.px, mit.tag, "pixel", 32'(pix), 32'(mit.px));
            chk(tick == mit.tk, mit.tag, "tick", 32'(tick), 32'(mit.tk));
        end
        prev_req = pix_req;
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int w);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        w = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctrl(bit en, bit hp, bit vp, bit rc);
        return {28'b0, rc, vp, hp, en};
    endfunction

    // driver: expected outputs of one frame, built from the requirements
    task automatic push_frame(bcfg_t b, int c0, bit tk0, string tag);
        bit uf = 1'b0;
        for (int k = 0; k < b.frame; k++) begin
            item_t x;
            int h = k % b.line;
            int c = c0 + k;
            bit dv = pv(c - 1);
            x.cyc = c;
            x.tag = tag;
            x.hs = (h < b.hsw) ^ b.hpol;                          // R3 R7
            x.vs = (k < b.vlen) ^ b.vpol;                         // R4 R7
            x.de = (h >= b.hs && h <= b.he &&
                    k >= b.vs + b.skew && k <= b.ve + b.skew);    // R5 R6
            if (x.de && !dv && b.recov) uf = 1'b1;                // R10
            if (!x.de)                          x.px = b.border;  // R8
            else if (!dv || (b.recov && uf))    x.px = b.fill;    // R9 R10
            else                                x.px = pd(c - 1);
            x.tk = (k == 0) && tk0;
            sbq.push_back(x);
        end
    endtask

    task automatic push_idle(bcfg_t b, int c, bit tk);
        item_t x;
        x.cyc = c; x.tag = "R12";
        x.hs = b.hpol; x.vs = b.vpol; x.de = 1'b0;
        x.px = b.border; x.tk = tk;
        sbq.push_back(x);
    endtask

    initial begin
        bcfg_t a, bb;
        int w, c0;
        a = '{line:10, hsw:2, frame:80, vlen:20, hs:3, he:7, vs:30, ve:69, skew:0,
              hpol:0, vpol:0, recov:0, border:24'h112233, fill:24'h0000FF};

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(hsync == 0 && vsync == 0 && de == 0 && tick == 0 && pix_req == 0,
            "R1", "ctrl outs in reset", {hsync, vsync, de, tick, pix_req}, 0);
        chk(pix == 0, "R1", "pixel in reset", 32'(pix), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hsync == 0 && vsync == 0 && de == 0 && tick == 0,
            "R1", "ctrl outs after reset", {hsync, vsync, de, tick}, 0);
        chk(pix == 0, "R1", "border reset value", 32'(pix), 0);

        wr(4'd1, (32'(a.line) << 16) | 32'(a.hsw), w);
        wr(4'd2, 32'(a.frame), w);
        wr(4'd3, 32'(a.vlen), w);
        wr(4'd4, (32'(a.he) << 16) | 32'(a.hs), w);
        wr(4'd5, 32'(a.vs), w);
        wr(4'd6, 32'(a.ve), w);
        wr(4'd7, 32'(a.skew), w);
        wr(4'd9, 32'(a.fill), w);
        wr(4'd8, 32'(a.border), w);
        repeat (3) @(negedge clk);
        // R12: idle raster follows the shadow settings, inactive levels
        chk(pix == a.border && de == 0 && hsync == 0 && vsync == 0,
            "R12", "idle outputs", 32'(pix), 32'(a.border));

        // R2: enable, first frame starts with sync; R9 starve with recovery off
        wr(4'd0, ctrl(1, 0, 0, 0), w);
        c0 = w + 2;
        sa = c0 + 33 - 1;
        push_frame(a, c0, 1'b0, "R2/R3/R4/R5/R8/R9");

        // R11: mid-frame rewrite of window, skew, polarity and recovery
        bb = a;
        bb.hs = 2; bb.he = 8; bb.skew = 5; bb.hpol = 1; bb.vpol = 1; bb.recov = 1;
        wr(4'd4, (32'(bb.he) << 16) | 32'(bb.hs), w);
        wr(4'd7, 32'(bb.skew), w);
        wr(4'd0, ctrl(1, 1, 1, 1), w);
        sb = c0 + 80 + 45 - 1;
        push_frame(bb, c0 + 80, 1'b1, "R6/R7/R10/R11");
        push_frame(bb, c0 + 160, 1'b1, "R10/R12");

        // R12: disable written mid-frame lands at the frame end
        while (cyc < c0 + 175) @(negedge clk);
        wr(4'd0, ctrl(0, 1, 1, 1), w);
        push_idle(bb, c0 + 240, 1'b1);
        for (int i = 1; i < 6; i++) push_idle(bb, c0 + 240 + i, 1'b0);

        while (sbq.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired cyc=%0d act=hung exp=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule